// File: doc/BRIEF.md
# Fractional-Order Difference Weight Generator

This block produces the weights of a truncated fractional-order difference operator (finite window of WIN_LEN+1 taps) for an order `gamma` that arrives as a signed fixed-point word. Positive orders give differentiator weights and negative orders give integrator weights. The weight at index 0 is one. Every later weight is the weight before it multiplied by a factor that depends only on the order and on the index. The block therefore computes the factors in a pipeline ahead of a single-multiplier recursion and delivers one weight per cycle to a coefficient store.

A one-cycle `start_i` pulse samples `gamma_i` and launches a run. Weights leave on a valid/ready stream that carries the index and the value. The consumer, typically the write port of a coefficient RAM, may hold `w_ready_i` low at any time. A weight is transferred on a rising edge where `w_valid_o` and `w_ready_i` are both high. While `w_ready_i` is low the whole pipeline stalls, and the presented index and value hold still. `busy_o` covers the run and `done_o` reports completion. The window length is a parameter, and values such as 100 and 400 elaborate from the same source.

All values use 24-bit two's complement with 17 fraction bits (Q7.17). That gives a range of about ±64 and a step of 2^-17.

Top module: `gl_weight_gen`

## Requirements
- R1: After reset is applied, whether idle or in the middle of a run, `busy_o`, `done_o` and `w_valid_o` are low.
- R2: The weight with index 0 is 1.0, which is the code 24'h020000 in Q7.17.
- R3: For j = 1..WIN_LEN the weight is computed in four steps. First rc_j = floor((2^24 + floor(j/2)) / j). Next q_j = (((1+gamma)·rc_j) + 2^23) >> 24, using an arithmetic shift, with 1+gamma in Q7.17. Then f_j = sat(2^17 − q_j). Finally w_j = sat((w_{j−1}·f_j + 2^16) >> 17). As a consequence, w_1 equals −gamma.
- R4: sat() clamps every result to the 24-bit limits 24'h7FFFFF and 24'h800000, on both the positive and the negative side.
- R5: One run delivers exactly WIN_LEN+1 weights with indexes 0, 1, …, WIN_LEN in ascending order. No further weight follows.
- R6: With `w_ready_i` held high, index 0 becomes valid after the third rising edge following the edge that samples `start_i`. Index j follows exactly j cycles later.
- R7: While `w_valid_o` is high and `w_ready_i` is low, the next cycle still shows `w_valid_o` high with the same index and value. No weight is lost or repeated.
- R8: `busy_o` is high from the edge that accepts a start until the edge that transfers index WIN_LEN. `done_o` rises in the cycle after that transfer and stays high, with no valid weight, until the next accepted start clears it.
- R9: A start pulse while `busy_o` is high is ignored. This includes a pulse in the cycle of the final transfer. The run continues with its original order and count.
- R10: `gamma_i` is sampled only when a start is accepted. Changing it during a run has no effect on the weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only when idle |
| gamma_i | input | 24 | Fractional order, signed Q7.17 |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run completed |
| w_valid_o | output | 1 | Weight stream valid |
| w_ready_i | input | 1 | Weight stream ready (back-pressure) |
| w_index_o | output | $clog2(WIN_LEN+1) | Index of the presented weight |
| w_data_o | output | 24 | Presented weight, signed Q7.17 |

## Verification
The sharp corner is the final transfer of index WIN_LEN landing on the same edge as a fresh start pulse. In that cycle the block must retire the run and at the same time refuse the start, because `busy_o` is still high. The bench raises `start_i` in the very cycle where it accepts the last weight. It then judges the result by requiring `done_o` high, `busy_o` low and no new valid weight for several cycles afterwards. A later normal start must still launch a clean run. A second overlap, a start pulse with a changed order injected mid-run under a stalling consumer, is judged against the model of the original order.

// File: rtl/gl_weight_pkg.sv
package gl_weight_pkg;

  localparam int WORD_W   = 24;
  localparam int FRAC_W   = 17;
  localparam int RCP_FRAC = 24;
  localparam int RCP_W    = RCP_FRAC + 1;
  localparam int ACC_W    = 56;

  typedef logic signed [WORD_W-1:0] word_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  localparam word_t UNITY   = word_t'(1 << FRAC_W);
  localparam acc_t  ACC_MAX = acc_t'((longint'(1) << (WORD_W-1)) - 1);
  localparam acc_t  ACC_MIN = acc_t'(-(longint'(1) << (WORD_W-1)));

  // clamp a wide signed value into the word range
  function automatic word_t sat_word(input acc_t v);
    if (v > ACC_MAX) return word_t'(ACC_MAX);
    if (v < ACC_MIN) return word_t'(ACC_MIN);
    return word_t'(v);
  endfunction

  // round half up, then drop sh fraction bits
  function automatic acc_t shr_round(input acc_t v, input int sh);
    return (v + (acc_t'(1) <<< (sh - 1))) >>> sh;
  endfunction

  // nearest reciprocal of j with RCP_FRAC fraction bits
  function automatic logic [RCP_W-1:0] recip_of(input int j);
    longint num;
    if (j <= 0) return '0;
    num = (longint'(1) << RCP_FRAC) + longint'(j / 2);
    return RCP_W'(num / longint'(j));
  endfunction

endpackage

// File: rtl/gl_seq_ctrl.sv
module gl_seq_ctrl
  import gl_weight_pkg::*;
#(
  parameter int WIN_LEN = 100,
  localparam int IDX_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  word_t            gamma_in,
  input  logic             adv,
  input  logic             last_take,
  output logic             busy,
  output logic             done,
  output logic             iss_valid,
  output logic [IDX_W-1:0] iss_idx,
  output word_t            gamma_q
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(WIN_LEN);

  logic             iss_act;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      iss_act <= 1'b0;
      cnt     <= '0;
      gamma_q <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      iss_act <= 1'b1;
      cnt     <= '0;
      gamma_q <= gamma_in;
    end else begin
      if (adv && iss_act) begin
        if (cnt == LAST) iss_act <= 1'b0;
        else             cnt     <= cnt + 1'b1;
      end
      if (last_take) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign iss_valid = iss_act;
  assign iss_idx   = cnt;

  // R9 R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !last_take) |=> (busy && $stable(gamma_q)));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> (done && !busy));

endmodule

// File: rtl/gl_recip_rom.sv
module gl_recip_rom
  import gl_weight_pkg::*;
#(
  parameter int WIN_LEN = 100,
  localparam int IDX_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic [RCP_W-1:0] out_rcp
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(WIN_LEN);

  logic [RCP_W-1:0] tbl [0:WIN_LEN];

  for (genvar k = 0; k <= WIN_LEN; k++) begin : g_tbl
    assign tbl[k] = recip_of(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_rcp   <= '0;
    end else if (en) begin
      out_valid <= in_valid;
      out_idx   <= in_idx;
      out_rcp   <= (in_idx <= LAST) ? tbl[in_idx] : '0;
    end
  end

endmodule

// File: rtl/gl_factor_stage.sv
module gl_factor_stage
  import gl_weight_pkg::*;
#(
  parameter int WIN_LEN = 100,
  localparam int IDX_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [RCP_W-1:0] in_rcp,
  input  word_t            gamma,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output word_t            out_fac
);

  acc_t  opg, prod, quot;
  word_t fac_c;

  always_comb begin
    opg   = acc_t'(gamma) + acc_t'(UNITY);
    prod  = opg * acc_t'({1'b0, in_rcp});
    quot  = shr_round(prod, RCP_FRAC);
    fac_c = sat_word(acc_t'(UNITY) - quot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_fac   <= '0;
    end else if (en) begin
      out_valid <= in_valid;
      out_idx   <= in_idx;
      out_fac   <= fac_c;
    end
  end

endmodule

// File: rtl/gl_weight_stage.sv
module gl_weight_stage
  import gl_weight_pkg::*;
#(
  parameter int WIN_LEN = 100,
  localparam int IDX_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ready,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  word_t            in_fac,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output word_t            out_data
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(WIN_LEN);

  acc_t  prod;
  word_t next_w;

  // recursion: the held output is the previous weight
  always_comb begin
    prod   = acc_t'(out_data) * acc_t'(in_fac);
    next_w = (in_idx == '0) ? UNITY : sat_word(shr_round(prod, FRAC_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_data  <= '0;
    end else if (en) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_idx  <= in_idx;
        out_data <= next_w;
      end
    end
  end

  // expected next index, tracked from handshakes only
  logic [IDX_W-1:0] exp_idx;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    exp_idx <= '0;
    else if (out_valid && ready)   exp_idx <= (out_idx == LAST) ? '0 : out_idx + 1'b1;
  end

  // R5
  idx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx == exp_idx));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ready) |=> (out_valid && $stable(out_idx) && $stable(out_data)));

endmodule

// File: rtl/gl_weight_gen.sv
module gl_weight_gen
  import gl_weight_pkg::*;
#(
  parameter int WIN_LEN = 100,
  localparam int IDX_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [23:0]      gamma_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             w_valid_o,
  input  logic             w_ready_i,
  output logic [IDX_W-1:0] w_index_o,
  output logic [23:0]      w_data_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(WIN_LEN);

  logic             adv, last_take;
  logic             iss_valid, a_valid, b_valid;
  logic [IDX_W-1:0] iss_idx, a_idx, b_idx;
  logic [RCP_W-1:0] a_rcp;
  word_t            gamma_q, b_fac, w_data;

  assign adv       = !w_valid_o || w_ready_i;
  assign last_take = w_valid_o && w_ready_i && (w_index_o == LAST);

  gl_seq_ctrl #(.WIN_LEN(WIN_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .gamma_in(word_t'(gamma_i)),
    .adv(adv), .last_take(last_take), .busy(busy_o), .done(done_o),
    .iss_valid(iss_valid), .iss_idx(iss_idx), .gamma_q(gamma_q)
  );

  gl_recip_rom #(.WIN_LEN(WIN_LEN)) u_rom (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_valid(iss_valid), .in_idx(iss_idx),
    .out_valid(a_valid), .out_idx(a_idx), .out_rcp(a_rcp)
  );

  gl_factor_stage #(.WIN_LEN(WIN_LEN)) u_fac (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_valid(a_valid), .in_idx(a_idx),
    .in_rcp(a_rcp), .gamma(gamma_q), .out_valid(b_valid), .out_idx(b_idx),
    .out_fac(b_fac)
  );

  gl_weight_stage #(.WIN_LEN(WIN_LEN)) u_wt (
    .clk(clk), .rst_n(rst_n), .en(adv), .ready(w_ready_i), .in_valid(b_valid),
    .in_idx(b_idx), .in_fac(b_fac), .out_valid(w_valid_o), .out_idx(w_index_o),
    .out_data(w_data)
  );

  assign w_data_o = w_data;

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!w_valid_o && !busy_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o) |-> !w_valid_o);

endmodule

// File: tb/gl_weight_gen_test.sv
`timescale 1ns/1ps
module gl_weight_gen_test;

  localparam int L  = 100;
  localparam int IW = $clog2(L + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [23:0]   gamma_i = '0;
  logic          w_ready_i = 1'b0;
  logic          busy_o, done_o, w_valid_o;
  logic [IW-1:0] w_index_o;
  logic [23:0]   w_data_o;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  logic [23:0] mdl [0:L];
  logic [23:0] got [0:L];

  always #2.5 clk = ~clk;

  gl_weight_gen #(.WIN_LEN(L)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .gamma_i(gamma_i),
    .busy_o(busy_o), .done_o(done_o), .w_valid_o(w_valid_o), .w_ready_i(w_ready_i),
    .w_index_o(w_index_o), .w_data_o(w_data_o)
  );

  typedef struct packed {
    logic [23:0] g;
    logic [1:0]  mode;
    logic [23:0] w1;
  } vec_t;

  // mode 0: ready high; 1: periodic stall; 2: stall plus start injected mid-run
  localparam vec_t VECS [0:4] = '{
    '{24'h006666, 2'd0, 24'hFF999A},
    '{24'hFECCCD, 2'd1, 24'h013333},
    '{24'h01FAE1, 2'd0, 24'hFE051F},
    '{24'h000000, 2'd1, 24'h000000},
    '{24'h006666, 2'd2, 24'hFF999A}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint satl(input longint v);
    if (v > 64'sd8388607)  return 64'sd8388607;
    if (v < -64'sd8388608) return -64'sd8388608;
    return v;
  endfunction

  task automatic build_model(input logic [23:0] g);
    longint gv, b, rc, q, f;
    gv = longint'(signed'(g));
    b  = 131072;
    mdl[0] = 24'h020000;
    for (int j = 1; j <= L; j++) begin
      rc = ((longint'(1) << 24) + longint'(j / 2)) / longint'(j);
      q  = ((131072 + gv) * rc + (longint'(1) << 23)) >>> 24;
      f  = satl(131072 - q);
      b  = satl((b * f + (longint'(1) << 16)) >>> 17);
      mdl[j] = b[23:0];
    end
  endtask

  task automatic run_one(input logic [23:0] g, input int mode, input logic [23:0] w1,
                         input bit collide);
    int n, taken, first;
    bit r, stalled, injected;
    logic [IW-1:0] st_idx;
    logic [23:0]   st_dat;
    build_model(g);
    @(negedge clk);
    gamma_i = g; start_i = 1'b1; w_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    n = 1; taken = 0; first = -1; stalled = 0; injected = 0;
    chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    chk(done_o == 1'b0, "R8 done cleared by start", done_o, 0);
    while (taken <= L && n < 4000) begin
      if (stalled) begin
        chk(w_valid_o && w_index_o == st_idx && w_data_o == st_dat, "R7 hold under stall",
            {w_valid_o, w_index_o, w_data_o}, {1'b1, st_idx, st_dat});
      end
      r = (mode == 0) ? 1'b1 : (n % 3 != 1);
      if (w_valid_o && first < 0) begin
        first = n;
        if (mode == 0) chk(first == 4, "R6 first weight latency", first, 4);
      end
      stalled = w_valid_o && !r;
      st_idx  = w_index_o;
      st_dat  = w_data_o;
      if (w_valid_o && r) begin
        chk(int'(w_index_o) == taken, "R5 index order", w_index_o, taken);
        if (mode == 0) chk(n - 4 == taken, "R6 one per cycle", n - 4, taken);
        chk(w_data_o == mdl[taken], "R3 weight value", w_data_o, mdl[taken]);
        if (taken == 0) chk(w_data_o == 24'h020000, "R2 unity weight", w_data_o, 24'h020000);
        if (taken == 1) chk(w_data_o == w1, "R3 first factor", w_data_o, w1);
        if (taken <= L) got[taken] = w_data_o;
        if (collide && taken == L) start_i = 1'b1;
        taken++;
      end
      if (mode == 2 && taken == 10 && !injected) begin
        start_i = 1'b1; gamma_i = 24'h7E0000; injected = 1;
      end
      w_ready_i = r;
      @(negedge clk);
      n++;
      start_i = 1'b0;
    end
    w_ready_i = 1'b0;
    chk(taken == L + 1, "R5 weight count", taken, L + 1);
    chk(done_o == 1'b1 && busy_o == 1'b0, "R8 done after last", {done_o, busy_o}, 2'b10);
    chk(w_valid_o == 1'b0, "R5 nothing after last", w_valid_o, 0);
    w_ready_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_o == 1'b1 && !w_valid_o && !busy_o, collide ? "R9 start at last ignored" : "R8 done held",
        {done_o, w_valid_o, busy_o}, 3'b100);
    w_ready_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL R5 watchdog expired actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !w_valid_o, "R1 reset state", {busy_o, done_o, w_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !w_valid_o, "R1 idle after reset", {busy_o, done_o, w_valid_o}, 0);

    for (int v = 0; v < 5; v++) begin
      run_one(VECS[v].g, int'(VECS[v].mode), VECS[v].w1, 1'b0);
    end

    // R4 positive saturation for a large integrating order
    run_one(24'h820000, 0, 24'h7E0000, 1'b0);
    chk(got[2] == 24'h7FFFFF, "R4 positive clamp", got[2], 24'h7FFFFF);

    // R4 both clamps for a large differentiating order
    run_one(24'h7E0000, 1, 24'h820000, 1'b0);
    chk(got[2] == 24'h7FFFFF, "R4 positive clamp", got[2], 24'h7FFFFF);
    chk(got[3] == 24'h800000, "R4 negative clamp", got[3], 24'h800000);

    // R3 integer order one gives a two-tap difference
    run_one(24'h020000, 0, 24'hFE0000, 1'b1);
    chk(got[2] == 24'h0 && got[L] == 24'h0, "R3 order one tail", {got[2], got[L]}, 0);

    // R9 start in the same cycle as the final transfer, then a normal run
    run_one(24'hFECCCD, 1, 24'h013333, 1'b1);
    run_one(24'h006666, 0, 24'hFF999A, 1'b0);

    // R1 reset in the middle of a run
    @(negedge clk);
    gamma_i = 24'h006666; start_i = 1'b1; w_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !w_valid_o, "R1 mid-run reset", {busy_o, done_o, w_valid_o}, 0);
    repeat (5) @(negedge clk);
    chk(!w_valid_o, "R1 quiet after reset", w_valid_o, 0);
    w_ready_i = 1'b0;

    run_one(24'h01FAE1, 1, 24'hFE051F, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule